// File: doc/BRIEF.md
# SIMD Adder with Register-Held Carries

This unit adds or subtracts two 64-bit operands split into independent lanes of 8, 16, 32 or 64 bits. The datapath has no global carry flag. Each lane computes its own carry (for addition) or borrow (for subtraction). These bits are packed into an ordinary register-sized word, which is returned to a register destination like any other result.

A third operand, itself a register of packed per-lane carry bits, feeds the add-with-carry and subtract-with-borrow operations. Multi-precision arithmetic is therefore built by chaining the carry word of one step into the next.

A delivery-mode select picks how the two results leave the unit:
- **Dual write:** the sum and the carry word appear together on two write ports.
- **Two-cycle:** the sum and then the carry word leave through one port on consecutive cycles.
- **Split-opcode:** the issue returns either only the sum or only the carry word, through one port.

Top module: `simd_carry_alu`

## Requirements
- R1: After reset, and until the first issue, `res_we_o`, `car_we_o` and `busy_o` are low and `res_o` and `car_o` are zero.
- R2: Lane width is 8 << `lane_sel_i` bits (0:8, 1:16, 2:32, 3:64). Each lane of the sum is computed modulo its width, and no carry or borrow crosses a lane boundary.
- R3: In the carry word, the carry or borrow of lane i sits in the least significant bit of lane i. Every other bit is zero.
- R4: For `op_i` = 1 (subtract), each lane gives a minus b modulo the lane width. The lane's flag is the borrow, 1 exactly when unsigned a < b.
- R5: For `op_i` = 2 (add with carry), lane i adds bit (least significant bit of lane i) of `cin_i`. All other bits of `cin_i` have no effect. For `op_i` = 0 (add), `cin_i` is ignored.
- R6: For `op_i` = 3 (subtract with borrow), lane i subtracts the borrow-in taken from the least significant bit of lane i of `cin_i`. The flag is 1 when unsigned a < b + borrow-in.
- R7: With `mode_i` = 0 (dual), an issue is followed one clock later by `res_o` = sum and `car_o` = carry word, with `res_we_o` and `car_we_o` high in that same cycle.
- R8: With `mode_i` = 1 (two-cycle), one clock after issue `res_o` = sum with `res_we_o` high. One clock after that, `res_o` = carry word with `res_we_o` high. `car_we_o` stays low throughout.
- R9: `busy_o` is high in the cycle between the two writes of a two-cycle operation. An issue presented in that cycle is ignored and produces no write.
- R10: With `mode_i` = 2, an issue writes only the sum on `res_o`. With `mode_i` = 3, an issue writes only the carry word on `res_o`. In both modes `car_we_o` stays low and there is one write per issue.
- R11: A cycle without an accepted issue, and with no pending second write, produces no write on either port in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Operation issue strobe |
| op_i | input | 2 | 0 add, 1 subtract, 2 add with carry, 3 subtract with borrow |
| lane_sel_i | input | 2 | Lane width select, width = 8 << value |
| mode_i | input | 2 | 0 dual, 1 two-cycle, 2 sum only, 3 carry only |
| src_a_i | input | 64 | First operand (minuend) |
| src_b_i | input | 64 | Second operand (subtrahend) |
| cin_i | input | 64 | Packed per-lane carry/borrow-in word |
| busy_o | output | 1 | Second cycle of a two-cycle operation in progress |
| res_o | output | 64 | Primary result port |
| res_we_o | output | 1 | Primary result write valid |
| car_o | output | 64 | Carry word port used in dual mode |
| car_we_o | output | 1 | Carry port write valid |

## Verification
The bench builds the unit with its default parameters: a 64-bit word cut into 8-bit slices. All four lane widths are therefore reachable, from eight byte lanes down to one full-word lane, and every slice-to-slice carry cut is exercised. A stimulus table is compared against an independent lane-by-lane reference. Directed cases then cover cin bits outside the lane LSBs, wrap-around borrows, and an issue attempted while the two-cycle mode is busy.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;

   typedef enum logic [1:0] {
      OP_ADD = 2'd0,
      OP_SUB = 2'd1,
      OP_ADC = 2'd2,
      OP_SBB = 2'd3
   } alu_op_e;

   typedef enum logic [1:0] {
      DM_DUAL  = 2'd0,
      DM_TWO   = 2'd1,
      DM_SUM   = 2'd2,
      DM_CARRY = 2'd3
   } dlv_mode_e;

   // bit 0 of the opcode selects subtraction
   function automatic logic op_is_sub(alu_op_e op);
      return op[0];
   endfunction

   // bit 1 of the opcode selects use of the carry-in operand
   function automatic logic op_uses_cin(alu_op_e op);
      return op[1];
   endfunction

endpackage

// File: rtl/simd_slice_add.sv
module simd_slice_add #(
   parameter int SLICE_W = 8
) (
   input  logic [SLICE_W-1:0] a_i,
   input  logic [SLICE_W-1:0] b_i,
   input  logic               c_i,
   input  logic               sub_i,
   output logic [SLICE_W-1:0] s_o,
   output logic               c_o
);

   logic [SLICE_W-1:0] b_eff;
   logic [SLICE_W:0]   total;

   assign b_eff = sub_i ? ~b_i : b_i;
   assign total = {1'b0, a_i} + {1'b0, b_eff} + {{SLICE_W{1'b0}}, c_i};
   assign s_o   = total[SLICE_W-1:0];
   assign c_o   = total[SLICE_W];

endmodule

// File: rtl/simd_lane_chain.sv
module simd_lane_chain #(
   parameter int DATA_W  = 64,
   parameter int SLICE_W = 8
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [DATA_W-1:0] cin_i,
   input  logic              sub_i,
   input  logic              use_cin_i,
   input  logic [1:0]        lane_sel_i,
   output logic [DATA_W-1:0] sum_o,
   output logic [DATA_W-1:0] cword_o
);

   localparam int NS   = DATA_W / SLICE_W;
   localparam int IDXW = $clog2(NS);

   logic [IDXW-1:0] span_m;
   logic [NS-1:0]   lane_start;
   logic [NS-1:0]   slice_ci;
   logic [NS-1:0]   slice_co;

   // slices per lane minus one, clamped to the word
   always_comb begin
      if (32'(lane_sel_i) >= IDXW) span_m = '1;
      else                         span_m = IDXW'((1 << lane_sel_i) - 1);
   end

   for (genvar s = 0; s < NS; s++) begin : g_slice
      localparam logic [IDXW-1:0] SIDX = IDXW'(s);
      logic            lane_c0;
      logic [IDXW-1:0] end_idx;
      logic            flag;

      always_comb begin
         lane_start[s] = ((SIDX & span_m) == '0);
         end_idx       = SIDX | span_m;
         lane_c0       = use_cin_i ? (cin_i[s*SLICE_W] ^ sub_i) : sub_i;
         flag          = slice_co[end_idx] ^ sub_i;
      end

      if (s == 0) begin : g_first
         assign slice_ci[s] = lane_c0;
      end else begin : g_link
         assign slice_ci[s] = lane_start[s] ? lane_c0 : slice_co[s-1];
      end

      simd_slice_add #(.SLICE_W(SLICE_W)) u_add (
         .a_i   (a_i[s*SLICE_W +: SLICE_W]),
         .b_i   (b_i[s*SLICE_W +: SLICE_W]),
         .c_i   (slice_ci[s]),
         .sub_i (sub_i),
         .s_o   (sum_o[s*SLICE_W +: SLICE_W]),
         .c_o   (slice_co[s])
      );

      assign cword_o[s*SLICE_W +: SLICE_W] =
         {{(SLICE_W-1){1'b0}}, lane_start[s] & flag};
   end

endmodule

// File: rtl/simd_result_seq.sv
module simd_result_seq
   import simd_alu_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_i,
   input  dlv_mode_e         mode_i,
   input  logic [DATA_W-1:0] sum_i,
   input  logic [DATA_W-1:0] cword_i,
   output logic              busy_o,
   output logic [DATA_W-1:0] res_o,
   output logic              res_we_o,
   output logic [DATA_W-1:0] car_o,
   output logic              car_we_o
);

   logic              pend_q;
   logic [DATA_W-1:0] pend_val_q;
   logic              accept;

   assign accept = issue_i & ~pend_q;
   assign busy_o = pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q     <= 1'b0;
         pend_val_q <= '0;
         res_o      <= '0;
         res_we_o   <= 1'b0;
         car_o      <= '0;
         car_we_o   <= 1'b0;
      end else begin
         res_we_o <= 1'b0;
         car_we_o <= 1'b0;
         if (pend_q) begin
            res_o    <= pend_val_q;
            res_we_o <= 1'b1;
            pend_q   <= 1'b0;
         end else if (accept) begin
            unique case (mode_i)
               DM_DUAL: begin
                  res_o    <= sum_i;
                  res_we_o <= 1'b1;
                  car_o    <= cword_i;
                  car_we_o <= 1'b1;
               end
               DM_TWO: begin
                  res_o      <= sum_i;
                  res_we_o   <= 1'b1;
                  pend_q     <= 1'b1;
                  pend_val_q <= cword_i;
               end
               DM_SUM: begin
                  res_o    <= sum_i;
                  res_we_o <= 1'b1;
               end
               DM_CARRY: begin
                  res_o    <= cword_i;
                  res_we_o <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/simd_carry_alu.sv
module simd_carry_alu
   import simd_alu_pkg::*;
#(
   parameter int DATA_W   = 64,
   parameter int MIN_LANE = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_i,
   input  logic [1:0]        op_i,
   input  logic [1:0]        lane_sel_i,
   input  logic [1:0]        mode_i,
   input  logic [DATA_W-1:0] src_a_i,
   input  logic [DATA_W-1:0] src_b_i,
   input  logic [DATA_W-1:0] cin_i,
   output logic              busy_o,
   output logic [DATA_W-1:0] res_o,
   output logic              res_we_o,
   output logic [DATA_W-1:0] car_o,
   output logic              car_we_o
);

   localparam int NUM_SLICE = DATA_W / MIN_LANE;

   if (MIN_LANE < 1 || (DATA_W % MIN_LANE) != 0) begin : g_bad_div
      $error("DATA_W must be a multiple of MIN_LANE");
   end
   if (NUM_SLICE < 2 || (NUM_SLICE & (NUM_SLICE - 1)) != 0) begin : g_bad_pow
      $error("DATA_W / MIN_LANE must be a power of two of at least 2");
   end

   alu_op_e           op;
   dlv_mode_e         mode;
   logic [DATA_W-1:0] sum_w;
   logic [DATA_W-1:0] cword_w;

   assign op   = alu_op_e'(op_i);
   assign mode = dlv_mode_e'(mode_i);

   simd_lane_chain #(.DATA_W(DATA_W), .SLICE_W(MIN_LANE)) u_chain (
      .a_i        (src_a_i),
      .b_i        (src_b_i),
      .cin_i      (cin_i),
      .sub_i      (op_is_sub(op)),
      .use_cin_i  (op_uses_cin(op)),
      .lane_sel_i (lane_sel_i),
      .sum_o      (sum_w),
      .cword_o    (cword_w)
   );

   simd_result_seq #(.DATA_W(DATA_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .issue_i  (issue_i),
      .mode_i   (mode),
      .sum_i    (sum_w),
      .cword_i  (cword_w),
      .busy_o   (busy_o),
      .res_o    (res_o),
      .res_we_o (res_we_o),
      .car_o    (car_o),
      .car_we_o (car_we_o)
   );

endmodule

// File: rtl/simd_carry_alu_chk.sv
module simd_carry_alu_chk #(
   parameter int DATA_W   = 64,
   parameter int MIN_LANE = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              issue_i,
   input logic [1:0]        mode_i,
   input logic              busy_o,
   input logic              res_we_o,
   input logic [DATA_W-1:0] car_o,
   input logic              car_we_o
);

   localparam int NUM_SLICE = DATA_W / MIN_LANE;

   logic [DATA_W-1:0] slice_lsb_m;
   always_comb begin
      slice_lsb_m = '0;
      for (int s = 0; s < NUM_SLICE; s++) slice_lsb_m[s*MIN_LANE] = 1'b1;
   end

   // R3
   carry_word_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      car_we_o |-> ((car_o & ~slice_lsb_m) == '0));

   // R7
   dual_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && !busy_o && mode_i == 2'd0) |=> (res_we_o && car_we_o));

   // R8
   two_cycle_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && !busy_o && mode_i == 2'd1) |=> (busy_o && res_we_o && !car_we_o));

   // R9
   busy_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> (res_we_o && !car_we_o && !busy_o));

   // R10
   single_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && !busy_o && mode_i[1]) |=> (res_we_o && !car_we_o && !busy_o));

   // R11
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!issue_i && !busy_o) |=> (!res_we_o && !car_we_o));

endmodule

bind simd_carry_alu simd_carry_alu_chk #(.DATA_W(DATA_W), .MIN_LANE(MIN_LANE)) u_chk (.*);

// File: tb/tb_simd_carry_alu.sv
module tb_simd_carry_alu;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 8;

   typedef struct packed {
      logic [1:0]  op;
      logic [1:0]  sel;
      logic [63:0] a;
      logic [63:0] b;
      logic [63:0] cin;
   } stim_t;

   localparam stim_t TBL [NVEC] = '{
      '{2'd0, 2'd0, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'h0},
      '{2'd0, 2'd1, 64'h8000_FFFF_7FFF_0001, 64'h8000_0001_0001_FFFF, 64'hFFFF_FFFF_FFFF_FFFF},
      '{2'd1, 2'd2, 64'h0000_0010_FFFF_FFFF, 64'h0000_0020_0000_0001, 64'h0},
      '{2'd1, 2'd3, 64'h1234_5678_0000_0000, 64'h1234_5678_0000_0001, 64'h0},
      '{2'd2, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101},
      '{2'd2, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0000_0000_0000_0001},
      '{2'd3, 2'd1, 64'h0000_0001_0000_0005, 64'h0000_0001_0000_0005, 64'h0001_0000_0001_0001},
      '{2'd3, 2'd2, 64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, 64'h0000_0001_0000_0001}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_i = 1'b0;
   logic [1:0]  op_i = '0;
   logic [1:0]  lane_sel_i = '0;
   logic [1:0]  mode_i = '0;
   logic [63:0] src_a_i = '0;
   logic [63:0] src_b_i = '0;
   logic [63:0] cin_i = '0;
   logic        busy_o;
   logic [63:0] res_o;
   logic        res_we_o;
   logic [63:0] car_o;
   logic        car_we_o;

   int n_checks = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   simd_carry_alu dut (
      .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i),
      .lane_sel_i(lane_sel_i), .mode_i(mode_i), .src_a_i(src_a_i),
      .src_b_i(src_b_i), .cin_i(cin_i), .busy_o(busy_o), .res_o(res_o),
      .res_we_o(res_we_o), .car_o(car_o), .car_we_o(car_we_o)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // lane-by-lane reference built from the requirements
   task automatic ref_op(input logic [1:0] op, input logic [1:0] sel,
                         input logic [63:0] a, input logic [63:0] b, input logic [63:0] cin,
                         output logic [63:0] s, output logic [63:0] c);
      int L;
      L = 8 << sel;
      s = '0;
      c = '0;
      for (int i = 0; i < 64 / L; i++) begin
         logic [65:0] m, la, lb, t, bi;
         m  = (66'd1 << L) - 66'd1;
         la = ({2'b0, a} >> (i*L)) & m;
         lb = ({2'b0, b} >> (i*L)) & m;
         bi = op[1] ? {65'd0, cin[i*L]} : 66'd0;
         if (!op[0]) begin
            t = la + lb + bi;
            c[i*L] = t[L];
         end else begin
            c[i*L] = (la < lb + bi);
            t = la - lb - bi;
         end
         s = s | 64'((t & m) << (i*L));
      end
   endtask

   task automatic drive(input logic [1:0] md, input logic [1:0] op, input logic [1:0] sel,
                        input logic [63:0] a, input logic [63:0] b, input logic [63:0] cin);
      mode_i = md; op_i = op; lane_sel_i = sel;
      src_a_i = a; src_b_i = b; cin_i = cin;
      issue_i = 1'b1;
      @(negedge clk);
      issue_i = 1'b0;
   endtask

   task automatic dual_case(input string req, input logic [1:0] op, input logic [1:0] sel,
                            input logic [63:0] a, input logic [63:0] b, input logic [63:0] cin,
                            input logic [63:0] es, input logic [63:0] ec);
      drive(2'd0, op, sel, a, b, cin);
      check({req, " sum"}, res_o, es);
      check({req, " carry"}, car_o, ec);
      check({req, " R7 both we"}, {62'd0, res_we_o, car_we_o}, 64'd3);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [63:0] es, ec, es2, ec2;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 res_we", {63'd0, res_we_o}, 64'd0);
      check("R1 car_we", {63'd0, car_we_o}, 64'd0);
      check("R1 busy", {63'd0, busy_o}, 64'd0);
      check("R1 res", res_o, 64'd0);
      check("R1 car", car_o, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", {62'd0, res_we_o, car_we_o}, 64'd0);

      // table walk, dual mode, against reference (R2 R3 R4 R5 R6)
      for (int k = 0; k < NVEC; k++) begin
         ref_op(TBL[k].op, TBL[k].sel, TBL[k].a, TBL[k].b, TBL[k].cin, es, ec);
         dual_case("R2 table", TBL[k].op, TBL[k].sel, TBL[k].a, TBL[k].b, TBL[k].cin, es, ec);
      end

      // R2 R3 byte lanes: carry stays in its lane
      dual_case("R2 byte", 2'd0, 2'd0, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001,
                64'h0, 64'h0, 64'h0001_0001_0001_0001);
      // R2 halfword lanes: same operands, carry moves within lane
      dual_case("R2 half", 2'd0, 2'd1, 64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001,
                64'h0, 64'h0100_0100_0100_0100, 64'h0);
      // R3 full-word lane wraps
      dual_case("R3 word", 2'd0, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 64'h0, 64'h1);
      // R4 subtract borrow per 32-bit lane
      dual_case("R4 sub", 2'd1, 2'd2, 64'h0000_0005_0000_0000, 64'h0000_0000_0000_0001,
                64'h0, 64'h0000_0005_FFFF_FFFF, 64'h1);
      // R5 add-with-carry: only lane LSB of cin counts
      dual_case("R5 adc", 2'd2, 2'd0, 64'h0000_0000_0000_10FF, 64'h0,
                64'h0000_0000_0000_FE01, 64'h0000_0000_0000_1000, 64'h1);
      // R5 plain add ignores cin
      dual_case("R5 add no cin", 2'd0, 2'd0, 64'h0000_0000_0000_10FF, 64'h0,
                64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_10FF, 64'h0);
      // R6 subtract with borrow
      dual_case("R6 sbb", 2'd3, 2'd1, 64'h0, 64'h0, 64'h0000_0000_0000_0001,
                64'h0000_0000_0000_FFFF, 64'h1);

      // R8 two-cycle delivery
      ref_op(2'd1, 2'd0, 64'h0102_0304_0506_0708, 64'h0201_0403_0605_0807, 64'h0, es, ec);
      drive(2'd1, 2'd1, 2'd0, 64'h0102_0304_0506_0708, 64'h0201_0403_0605_0807, 64'h0);
      check("R8 first sum", res_o, es);
      check("R8 first we", {61'd0, res_we_o, car_we_o, busy_o}, 64'b101);
      // R9 issue while busy is ignored
      drive(2'd0, 2'd0, 2'd3, 64'h5, 64'h6, 64'h0);
      check("R8 second carry", res_o, ec);
      check("R9 second we", {61'd0, res_we_o, car_we_o, busy_o}, 64'b100);
      @(negedge clk);
      check("R9 ignored issue", {62'd0, res_we_o, car_we_o}, 64'd0);
      check("R9 port kept", res_o, ec);

      // R10 split opcodes
      ref_op(2'd0, 2'd2, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF, 64'h0, es2, ec2);
      drive(2'd2, 2'd0, 2'd2, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF, 64'h0);
      check("R10 sum only", res_o, es2);
      check("R10 sum we", {61'd0, res_we_o, car_we_o, busy_o}, 64'b100);
      drive(2'd3, 2'd0, 2'd2, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF, 64'h0);
      check("R10 carry only", res_o, ec2);
      check("R10 carry we", {61'd0, res_we_o, car_we_o, busy_o}, 64'b100);

      // R11 idle cycle
      @(negedge clk);
      check("R11 idle", {61'd0, res_we_o, car_we_o, busy_o}, 64'd0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule